// File: doc/BRIEF.md
# Synchronous FIFO with Loadable Flag Thresholds

A single-clock first-in first-out buffer, 4096 words deep and 9 bits wide by default. It has one write port and one read port, and it drives active-low full, empty, almost-empty and almost-full flags. The almost flags compare the stored word count with two programmable thresholds.

A mode input, `load_i`, chooses what the two data ports reach. When it is high, the ports reach the storage array. When it is low, they reach four threshold byte registers. These registers are visited one after another by a shared two-bit selector, which wraps around: empty-threshold low byte, empty-threshold high part, full-threshold low byte, full-threshold high part.

Software, or a neighbouring block, programs the thresholds by writing four words through the data input. It can read them back by issuing four reads through the data output.

Top module: `prog_flag_fifo`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, the flags are as follows:
  - `empty_no` = 0 and `almost_empty_no` = 0;
  - `full_no` = 1 and `almost_full_no` = 1;
  - both thresholds equal 7, and the selector points at the empty-threshold low byte.
- R2: With `load_i` = 0 and `wr_en_i` = 1, each rising clock edge writes `wdata_i` into the selected threshold register and then advances the selector. The order is empty low, empty high, full low, full high, then back to empty low.
  - Low registers keep `wdata_i[7:0]`.
  - High registers keep `wdata_i[3:0]` as threshold bits 11:8. All other data bits are dropped.
- R3: With `load_i` = 0, `rd_en_i` = 1 and `wr_en_i` = 0, each rising edge loads the selected register onto `rdata_o`, zero-extended, and advances the same shared selector.
- R4: With `load_i` = 1 and `wr_en_i` = 1, a word is stored in the array, unless the array is full.
  - `wr_en_i` = 0 writes nothing in either mode.
  - With both enables low, no flag changes and `rdata_o` holds its value.
- R5: With `load_i` = 1 and `rd_en_i` = 1 on a non-empty array, the oldest word appears on `rdata_o` after that rising edge, so words leave in write order.
  - A write and a read in the same cycle both take effect.
- R6: `full_no` goes low when the array holds exactly 4096 words, that is, after 4096 writes with no reads since reset. Writes are then ignored.
- R7: `empty_no` is low when the array holds no word. Reads are then ignored and `rdata_o` keeps its value.
- R8: `almost_empty_no` is low exactly when the stored count is less than or equal to the empty threshold.
- R9: `almost_full_no` is low exactly when (4096 minus the count) is less than or equal to the full threshold.
- R10: If a threshold write and a threshold read are requested in the same cycle, the write is performed. The selector advances by one step, and `rdata_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | 1: ports reach the array; 0: ports reach the threshold registers |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | 9 | Write data |
| rd_en_i | input | 1 | Read request |
| rdata_o | output | 9 | Registered read data |
| full_no | output | 1 | Array full, active low |
| empty_no | output | 1 | Array empty, active low |
| almost_full_no | output | 1 | Free space at or below the full threshold, active low |
| almost_empty_no | output | 1 | Count at or below the empty threshold, active low |

## Verification
The bench builds the block with its default parameters: 4096 words of 9 bits, which gives a 12-bit threshold whose high register holds 4 bits. This depth still allows the bench to fill the array completely and drain it again. As a result, the full-flag edge at exactly 4096 words, the ignored overflow write and the almost-full threshold crossing near the top are all reached.

The bench also uses a full threshold above 255. This exercises the high threshold register and the masking of its unused data bits.

// File: rtl/pff_pkg.sv
package pff_pkg;
  typedef enum logic [1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } off_sel_e;

  localparam int unsigned LO_W      = 8;
  localparam int unsigned RESET_THR = 7;
endpackage

// File: rtl/pff_offset_regs.sv
module pff_offset_regs
  import pff_pkg::*;
#(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned OFF_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rback_o,
  output logic [OFF_W-1:0] empty_thr_o,
  output logic [OFF_W-1:0] full_thr_o,
  output logic [1:0]       sel_o
);
  localparam int unsigned HI_W = OFF_W - LO_W;

  off_sel_e        sel_q;
  logic [LO_W-1:0] e_lo_q, f_lo_q;
  logic [HI_W-1:0] e_hi_q, f_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SEL_EMPTY_LO;
      e_lo_q <= LO_W'(RESET_THR);
      f_lo_q <= LO_W'(RESET_THR);
      e_hi_q <= '0;
      f_hi_q <= '0;
    end else begin
      if (wr_i) begin
        unique case (sel_q)
          SEL_EMPTY_LO: e_lo_q <= wdata_i[LO_W-1:0];
          SEL_EMPTY_HI: e_hi_q <= wdata_i[HI_W-1:0];
          SEL_FULL_LO:  f_lo_q <= wdata_i[LO_W-1:0];
          SEL_FULL_HI:  f_hi_q <= wdata_i[HI_W-1:0];
          default: ;
        endcase
      end
      // reads and writes share one selector
      if (wr_i || rd_i) sel_q <= off_sel_e'(sel_q + 2'd1);
    end
  end

  always_comb begin
    rback_o = '0;
    unique case (sel_q)
      SEL_EMPTY_LO: rback_o[LO_W-1:0] = e_lo_q;
      SEL_EMPTY_HI: rback_o[HI_W-1:0] = e_hi_q;
      SEL_FULL_LO:  rback_o[LO_W-1:0] = f_lo_q;
      SEL_FULL_HI:  rback_o[HI_W-1:0] = f_hi_q;
      default: ;
    endcase
  end

  assign empty_thr_o = {e_hi_q, e_lo_q};
  assign full_thr_o  = {f_hi_q, f_lo_q};
  assign sel_o       = sel_q;
endmodule

// File: rtl/pff_ptr_ctrl.sv
module pff_ptr_ctrl #(
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  output logic          do_wr_o,
  output logic          do_rd_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] count_o
);
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  assign do_wr_o = wr_req_i && (cnt_q != CW'(DEPTH));
  assign do_rd_o = rd_req_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr_o) wptr_q <= wptr_q + AW'(1);
      if (do_rd_o) rptr_q <= rptr_q + AW'(1);
      unique case ({do_wr_o, do_rd_o})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: ;
      endcase
    end
  end

  assign waddr_o = wptr_q;
  assign raddr_o = rptr_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/pff_ram.sv
module pff_ram #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/pff_flags.sv
module pff_flags #(
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] empty_thr_i,
  input  logic [AW-1:0] full_thr_i,
  output logic          full_no,
  output logic          empty_no,
  output logic          almost_full_no,
  output logic          almost_empty_no
);
  logic [CW-1:0] free;

  assign free            = CW'(DEPTH) - count_i;
  assign full_no         = (count_i != CW'(DEPTH));
  assign empty_no        = (count_i != '0);
  assign almost_empty_no = !(count_i <= {1'b0, empty_thr_i});
  assign almost_full_no  = !(free <= {1'b0, full_thr_i});
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_no,
  output logic             empty_no,
  output logic             almost_full_no,
  output logic             almost_empty_no
);
  logic             off_wr, off_rd, do_wr, do_rd;
  logic [WIDTH-1:0] off_rback, ram_rdata, rdata_q;
  logic [AW-1:0]    empty_thr, full_thr, waddr, raddr;
  logic [CW-1:0]    count;
  logic [1:0]       off_sel;

  assign off_wr = !load_i && wr_en_i;
  // write wins over a same-cycle threshold read
  assign off_rd = !load_i && rd_en_i && !wr_en_i;

  pff_offset_regs #(.WIDTH(WIDTH), .OFF_W(AW)) u_off (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (off_wr),
    .rd_i        (off_rd),
    .wdata_i     (wdata_i),
    .rback_o     (off_rback),
    .empty_thr_o (empty_thr),
    .full_thr_o  (full_thr),
    .sel_o       (off_sel)
  );

  pff_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (load_i && wr_en_i),
    .rd_req_i (load_i && rd_en_i),
    .do_wr_o  (do_wr),
    .do_rd_o  (do_rd),
    .waddr_o  (waddr),
    .raddr_o  (raddr),
    .count_o  (count)
  );

  pff_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (do_wr),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (ram_rdata)
  );

  pff_flags #(.DEPTH(DEPTH)) u_flags (
    .count_i         (count),
    .empty_thr_i     (empty_thr),
    .full_thr_i      (full_thr),
    .full_no         (full_no),
    .empty_no        (empty_no),
    .almost_full_no  (almost_full_no),
    .almost_empty_no (almost_empty_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (do_rd)  rdata_q <= ram_rdata;
    else if (off_rd) rdata_q <= off_rback;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
  parameter int unsigned WIDTH = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic             full_no,
  input logic             empty_no,
  input logic             almost_full_no,
  input logic             almost_empty_no,
  input logic [1:0]       sel_i
);
  assert_sel_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && wr_en_i) |=> (sel_i == 2'($past(sel_i) + 2'd1)));

  assert_rd_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && rd_en_i && !wr_en_i) |=> (sel_i == 2'($past(sel_i) + 2'd1)));

  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !rd_en_i) |=> ($stable(rdata_o) && $stable(full_no) && $stable(empty_no)
                               && $stable(almost_full_no) && $stable(almost_empty_no)));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && load_i && !rd_en_i) |=> !full_no);

  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_no && load_i && !wr_en_i) |=> (!empty_no && $stable(rdata_o)));

  assert_empty_implies_ae_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_no |-> !almost_empty_no);

  assert_full_implies_af_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> !almost_full_no);

  assert_wr_priority_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && wr_en_i && rd_en_i) |=> $stable(rdata_o));

  always_comb begin
    if (rst_ni) assert_flags_exclusive_R6: assert (!(!full_no && !empty_no));
  end
endmodule

bind prog_flag_fifo pff_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .load_i          (load_i),
  .wr_en_i         (wr_en_i),
  .rd_en_i         (rd_en_i),
  .rdata_o         (rdata_o),
  .full_no         (full_no),
  .empty_no        (empty_no),
  .almost_full_no  (almost_full_no),
  .almost_empty_no (almost_empty_no),
  .sel_i           (off_sel)
);

// File: tb/prog_flag_fifo_test.sv
module prog_flag_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4096;
  localparam int WIDTH = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [WIDTH-1:0] wdata_i = '0;
  logic [WIDTH-1:0] rdata_o;
  logic full_no, empty_no, almost_full_no, almost_empty_no;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_flag_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .full_no(full_no), .empty_no(empty_no),
    .almost_full_no(almost_full_no), .almost_empty_no(almost_empty_no)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [WIDTH-1:0] exp_q[$];
  int mcnt = 0;
  logic [WIDTH-1:0] mrd = '0;
  logic [7:0] moff[4];
  int msel = 0;

  function automatic int thr_e();
    return {moff[1][3:0], moff[0]};
  endfunction
  function automatic int thr_f();
    return {moff[3][3:0], moff[2]};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_flags();
    chk("R6 full_no", full_no, (mcnt == DEPTH) ? 0 : 1);
    chk("R7 empty_no", empty_no, (mcnt == 0) ? 0 : 1);
    chk("R8 almost_empty_no", almost_empty_no, (mcnt <= thr_e()) ? 0 : 1);
    chk("R9 almost_full_no", almost_full_no, ((DEPTH - mcnt) <= thr_f()) ? 0 : 1);
  endtask

  task automatic step(logic ld, logic we, logic [WIDTH-1:0] wd, logic re);
    load_i = ld; wr_en_i = we; wdata_i = wd; rd_en_i = re;
    @(posedge clk); #1;
  endtask

  // driver: pushes expected words into the scoreboard
  task automatic fifo_wr(logic [WIDTH-1:0] wd);
    if (mcnt < DEPTH) begin exp_q.push_back(wd); mcnt++; end
    step(1, 1, wd, 0);
    chk_flags();
  endtask

  // monitor: pops and compares what the design returns
  task automatic fifo_rd(string tag);
    if (mcnt > 0) begin mrd = exp_q.pop_front(); mcnt--; end
    step(1, 0, '0, 1);
    chk(tag, rdata_o, mrd);
    chk_flags();
  endtask

  task automatic fifo_both(logic [WIDTH-1:0] wd);
    logic rd_ok, wr_ok;
    rd_ok = (mcnt > 0);
    wr_ok = (mcnt < DEPTH);
    if (rd_ok) mrd = exp_q.pop_front();
    if (wr_ok) exp_q.push_back(wd);
    mcnt = mcnt + (wr_ok ? 1 : 0) - (rd_ok ? 1 : 0);
    step(1, 1, wd, 1);
    chk("R5 simultaneous rd/wr", rdata_o, mrd);
    chk_flags();
  endtask

  task automatic off_wr(logic [WIDTH-1:0] wd);
    moff[msel] = (msel[0]) ? {4'h0, wd[3:0]} : wd[7:0];
    msel = (msel + 1) % 4;
    step(0, 1, wd, 0);
    chk_flags();
  endtask

  task automatic off_rd(string tag);
    mrd = {1'b0, moff[msel]};
    msel = (msel + 1) % 4;
    step(0, 0, '0, 1);
    chk(tag, rdata_o, mrd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    moff[0] = 8'd7; moff[1] = 8'd0; moff[2] = 8'd7; moff[3] = 8'd0;
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 empty_no", empty_no, 0);
    chk("R1 almost_empty_no", almost_empty_no, 0);
    chk("R1 full_no", full_no, 1);
    chk("R1 almost_full_no", almost_full_no, 1);

    // R3 default readback, wrap included
    for (int i = 0; i < 8; i++) off_rd("R3 default readback");

    // R4 idle cycles leave the selector where it is
    step(0, 0, 9'h1AB, 0);
    step(1, 0, 9'h055, 0);
    chk_flags();
    chk("R4 idle rdata", rdata_o, mrd);

    // R2 program thresholds: empty 16, full 0x120, high bits masked
    off_wr(9'h010);
    off_wr(9'h1F0);
    off_wr(9'h020);
    off_wr(9'h1F1);
    chk("R2 empty thr model", thr_e(), 16);
    chk("R2 full thr model", thr_f(), 288);
    for (int i = 0; i < 4; i++) off_rd("R2 readback after write");

    // R10 write and read together: write wins, rdata holds
    moff[msel] = 8'h10;
    msel = (msel + 1) % 4;
    step(0, 1, 9'h010, 1);
    chk("R10 rdata held", rdata_o, mrd);
    off_rd("R10 selector advanced once");
    off_rd("R3 readback");
    off_rd("R3 readback");

    // R7 read on empty array is ignored
    fifo_rd("R7 read when empty");

    // R4 R5 R6 R8 R9 fill to full
    for (int i = 0; i < DEPTH; i++) fifo_wr(9'(i * 37 + 5));
    chk("R6 full after 4096 writes", full_no, 0);
    fifo_wr(9'h1FF);
    fifo_wr(9'h0EE);

    // R5 drain in order
    for (int i = 0; i < DEPTH; i++) fifo_rd("R5 read order");
    fifo_rd("R7 read when empty");
    fifo_rd("R7 read when empty");

    // R5 mixed traffic
    fifo_wr(9'h101);
    fifo_wr(9'h102);
    fifo_both(9'h103);
    fifo_both(9'h104);
    fifo_rd("R5 read after mixed");
    fifo_rd("R5 read after mixed");
    fifo_both(9'h105);
    fifo_rd("R5 read after mixed");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule